// File: doc/BRIEF.md
# Instruction Fetch Exception Detector

This block sits beside the fetch stage. It looks at every fetched 32-bit instruction word and at the status returned with it, and raises one of two instruction-side exceptions. An illegal-opcode exception is raised when the six-bit major opcode is not in the valid set. The valid set is a 64-entry mask parameter. Optional instruction groups are removed from it at run time when their enables are low. An all-zero word can also be made illegal. An instruction-bus exception is raised for an uncorrectable ECC error on a local-memory fetch, and for a correctable ECC error when reporting of those errors is switched on. It is also raised for an error response from the cached bus, but only when that fetch bypassed the cache.

Each fetch-valid beat is judged in a single cycle. The result is registered, so an exception appears as a one-cycle pulse in the cycle after the beat. The pipeline stage that consumes the pulses owns flush, vectoring and cause capture.

Top module: `ifetch_exc_detect`

## Requirements
- R1: While `rst_ni` is low, both `illegal_exc_o` and `bus_exc_o` are 0, whatever the other inputs are.
- R2: The major opcode is `instr_i[31:26]`, which are bits 0 to 5 in MSB-first numbering. An illegal-opcode exception is raised when the mask bit indexed by the opcode value is 0. With the default mask, opcodes 0x07, 0x0F and 0x3F are invalid and opcodes such as 0x01 and 0x20 are valid.
- R3: `instr_i[25:0]` have no effect on the illegal-opcode decision. The only exception is the all-zero word rule in R5.
- R4: Bit g of `opt_en_i` enables optional group g. When the bit is 0, the group's opcodes are illegal. By default group 0 is {0x10} and group 1 is {0x12, 0x16}.
- R5: When `zero_chk_en_i` is 1, the word 0x00000000 is illegal. When it is 0, opcode 0x00 is treated like any other valid opcode.
- R6: A local-memory fetch (`fetch_src_i` = 0) with `ecc_ue_i` = 1 raises the bus exception.
- R7: A local-memory fetch with `ecc_ce_i` = 1 raises the bus exception only when `ce_report_en_i` = 1.
- R8: A cached-bus fetch (`fetch_src_i` = 1) whose `bus_resp_i` differs from 2'b00 (OKAY) raises the bus exception only when `cache_en_i` = 0 or `inhibit_cache_i` = 1. Otherwise the response is ignored. The ECC flags are ignored on cached-bus fetches.
- R9: Exceptions are single-cycle pulses in the cycle after a beat with `fetch_valid_i` = 1. A cycle with `fetch_valid_i` = 0 produces no pulse in the next cycle.
- R10: When a beat qualifies for both exceptions, only `illegal_exc_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetched word and its status are present |
| instr_i | input | 32 | Fetched instruction word |
| fetch_src_i | input | 1 | 0 = local memory, 1 = cached bus |
| ecc_ue_i | input | 1 | Local-memory uncorrectable ECC error |
| ecc_ce_i | input | 1 | Local-memory correctable ECC error |
| bus_resp_i | input | 2 | Cached-bus response, 2'b00 = OKAY |
| cache_en_i | input | 1 | Instruction cache enabled |
| inhibit_cache_i | input | 1 | Fetch address has the inhibit-caching attribute |
| opt_en_i | input | 2 | Enables for the optional instruction groups |
| zero_chk_en_i | input | 1 | Treat the all-zero word as illegal |
| ce_report_en_i | input | 1 | Report correctable ECC errors |
| illegal_exc_o | output | 1 | Illegal-opcode exception pulse |
| bus_exc_o | output | 1 | Instruction-bus exception pulse |

## Verification
The assertions assume that the configuration inputs (`opt_en_i`, `zero_chk_en_i`, `ce_report_en_i`) and the status flags are valid whenever `fetch_valid_i` is high. They also assume that a fetch has exactly one source, chosen by `fetch_src_i`. The stimulus changes configuration only between beats. It drives the ECC flags and the bus response together with the word they belong to, and it includes deliberately contradictory combinations, such as ECC flags on a cached-bus fetch. Status flags driven on idle cycles test that nothing leaks out when no fetch is valid.

// File: rtl/ifx_pkg.sv
`timescale 1ns/1ps
package ifx_pkg;
  typedef enum logic {
    SRC_LMEM = 1'b0,
    SRC_CBUS = 1'b1
  } fetch_src_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic illegal;
    logic bus;
  } exc_flags_t;
endpackage

// File: rtl/ifx_opcode_check.sv
`timescale 1ns/1ps
module ifx_opcode_check #(
  parameter int INSTR_W     = 32,
  parameter int OP_W        = 6,
  parameter int NUM_OPT_GRP = 2,
  localparam int OPS        = 1 << OP_W,
  parameter logic [OPS-1:0] BASE_MASK = 64'h7FFF_FFFF_FFFF_7F7F,
  parameter logic [NUM_OPT_GRP-1:0][OPS-1:0] OPT_GRP_MASKS =
    {64'h0000_0000_0044_0000, 64'h0000_0000_0001_0000}
) (
  input  logic [INSTR_W-1:0]     instr_i,
  input  logic [NUM_OPT_GRP-1:0] opt_en_i,
  input  logic                   zero_chk_en_i,
  output logic                   illegal_o
);
  logic [NUM_OPT_GRP:0][OPS-1:0] mask_chain;
  logic [OP_W-1:0]               major;

  assign mask_chain[0] = BASE_MASK;

  // strip each disabled optional group from the valid set
  for (genvar g = 0; g < NUM_OPT_GRP; g++) begin : g_strip
    assign mask_chain[g+1] = opt_en_i[g] ? mask_chain[g]
                                         : (mask_chain[g] & ~OPT_GRP_MASKS[g]);
  end

  assign major     = instr_i[INSTR_W-1 -: OP_W];
  assign illegal_o = ~mask_chain[NUM_OPT_GRP][major]
                   | (zero_chk_en_i & (instr_i == '0));
endmodule

// File: rtl/ifx_bus_check.sv
`timescale 1ns/1ps
module ifx_bus_check
  import ifx_pkg::*;
#(
  parameter int RESP_W = 2
) (
  input  logic              fetch_src_i,
  input  logic              ecc_ue_i,
  input  logic              ecc_ce_i,
  input  logic              ce_report_en_i,
  input  logic [RESP_W-1:0] bus_resp_i,
  input  logic              cache_en_i,
  input  logic              inhibit_cache_i,
  output logic              bus_err_o
);
  logic lmem_err, cbus_err, bypass;

  assign lmem_err = ecc_ue_i | (ecc_ce_i & ce_report_en_i);
  assign bypass   = ~cache_en_i | inhibit_cache_i;
  assign cbus_err = (bus_resp_i != RESP_W'(RESP_OKAY)) & bypass;

  always_comb begin
    unique case (fetch_src_e'(fetch_src_i))
      SRC_LMEM: bus_err_o = lmem_err;
      SRC_CBUS: bus_err_o = cbus_err;
      default:  bus_err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ifetch_exc_detect.sv
`timescale 1ns/1ps
module ifetch_exc_detect
  import ifx_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int OP_W        = 6,
  parameter int NUM_OPT_GRP = 2,
  parameter int RESP_W      = 2,
  localparam int OPS        = 1 << OP_W,
  parameter logic [OPS-1:0] BASE_MASK = 64'h7FFF_FFFF_FFFF_7F7F,
  parameter logic [NUM_OPT_GRP-1:0][OPS-1:0] OPT_GRP_MASKS =
    {64'h0000_0000_0044_0000, 64'h0000_0000_0001_0000}
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fetch_valid_i,
  input  logic [INSTR_W-1:0]     instr_i,
  input  logic                   fetch_src_i,
  input  logic                   ecc_ue_i,
  input  logic                   ecc_ce_i,
  input  logic [RESP_W-1:0]      bus_resp_i,
  input  logic                   cache_en_i,
  input  logic                   inhibit_cache_i,
  input  logic [NUM_OPT_GRP-1:0] opt_en_i,
  input  logic                   zero_chk_en_i,
  input  logic                   ce_report_en_i,
  output logic                   illegal_exc_o,
  output logic                   bus_exc_o
);
  logic       op_illegal, bus_err;
  exc_flags_t exc_d, exc_q;

  ifx_opcode_check #(
    .INSTR_W(INSTR_W), .OP_W(OP_W), .NUM_OPT_GRP(NUM_OPT_GRP),
    .BASE_MASK(BASE_MASK), .OPT_GRP_MASKS(OPT_GRP_MASKS)
  ) u_opc (
    .instr_i(instr_i), .opt_en_i(opt_en_i),
    .zero_chk_en_i(zero_chk_en_i), .illegal_o(op_illegal)
  );

  ifx_bus_check #(.RESP_W(RESP_W)) u_bus (
    .fetch_src_i(fetch_src_i), .ecc_ue_i(ecc_ue_i), .ecc_ce_i(ecc_ce_i),
    .ce_report_en_i(ce_report_en_i), .bus_resp_i(bus_resp_i),
    .cache_en_i(cache_en_i), .inhibit_cache_i(inhibit_cache_i),
    .bus_err_o(bus_err)
  );

  // illegal opcode wins; a single cause per beat
  always_comb begin
    exc_d.illegal = fetch_valid_i & op_illegal;
    exc_d.bus     = fetch_valid_i & bus_err & ~op_illegal;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exc_q <= '0;
    else         exc_q <= exc_d;
  end

  assign illegal_exc_o = exc_q.illegal;
  assign bus_exc_o     = exc_q.bus;
endmodule

// File: rtl/ifx_exc_sva.sv
`timescale 1ns/1ps
module ifx_exc_sva #(
  parameter int INSTR_W = 32,
  parameter int RESP_W  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fetch_valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               fetch_src_i,
  input logic               ecc_ue_i,
  input logic               ecc_ce_i,
  input logic [RESP_W-1:0]  bus_resp_i,
  input logic               cache_en_i,
  input logic               inhibit_cache_i,
  input logic               zero_chk_en_i,
  input logic               ce_report_en_i,
  input logic               illegal_exc_o,
  input logic               bus_exc_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (!illegal_exc_o && !bus_exc_o) || !rst_ni); // R1

  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && zero_chk_en_i && (instr_i == '0) |=> illegal_exc_o); // R5

  AST_UE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && !fetch_src_i && ecc_ue_i |=> illegal_exc_o || bus_exc_o); // R6

  AST_CE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && !fetch_src_i && !ecc_ue_i && !ce_report_en_i |=> !bus_exc_o); // R7

  AST_CACHED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && fetch_src_i && cache_en_i && !inhibit_cache_i |=> !bus_exc_o); // R8

  AST_CBUS_OKAY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && fetch_src_i && (bus_resp_i == '0) |=> !bus_exc_o); // R8

  AST_NO_BEAT_NO_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !illegal_exc_o && !bus_exc_o); // R9

  AST_SINGLE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_exc_o && bus_exc_o)); // R10
endmodule

bind ifetch_exc_detect ifx_exc_sva #(.INSTR_W(INSTR_W), .RESP_W(RESP_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i),
  .instr_i(instr_i), .fetch_src_i(fetch_src_i), .ecc_ue_i(ecc_ue_i),
  .ecc_ce_i(ecc_ce_i), .bus_resp_i(bus_resp_i), .cache_en_i(cache_en_i),
  .inhibit_cache_i(inhibit_cache_i), .zero_chk_en_i(zero_chk_en_i),
  .ce_report_en_i(ce_report_en_i), .illegal_exc_o(illegal_exc_o),
  .bus_exc_o(bus_exc_o)
);

// File: tb/sim_ifetch_exc_detect.sv
`timescale 1ns/1ps
module sim_ifetch_exc_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        fetch_src = 1'b0;
  logic        ecc_ue = 1'b0, ecc_ce = 1'b0;
  logic [1:0]  bus_resp = 2'b00;
  logic        cache_en = 1'b1, inhibit = 1'b0;
  logic [1:0]  opt_en = 2'b11;
  logic        zero_en = 1'b1, ce_rep = 1'b1;
  logic        ill_o, bus_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ifetch_exc_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fetch_valid), .instr_i(instr),
    .fetch_src_i(fetch_src), .ecc_ue_i(ecc_ue), .ecc_ce_i(ecc_ce),
    .bus_resp_i(bus_resp), .cache_en_i(cache_en), .inhibit_cache_i(inhibit),
    .opt_en_i(opt_en), .zero_chk_en_i(zero_en), .ce_report_en_i(ce_rep),
    .illegal_exc_o(ill_o), .bus_exc_o(bus_o)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {illegal,bus} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] low);
    return {op, low};
  endfunction

  // caller is at a negedge; drive a beat, check the pulse, then check it is gone
  task automatic beat(input string req, input logic src, input logic [31:0] w,
                      input logic ue, input logic ce, input logic [1:0] rsp,
                      input logic ill_e, input logic bus_e);
    fetch_valid = 1'b1; fetch_src = src; instr = w;
    ecc_ue = ue; ecc_ce = ce; bus_resp = rsp;
    @(negedge clk);
    chk(req, {ill_o, bus_o}, {ill_e, bus_e});
    fetch_valid = 1'b0;
    @(negedge clk);
    chk({req, " R9 pulse ends"}, {ill_o, bus_o}, 2'b00);
  endtask

  task automatic t_reset;
    fetch_valid = 1'b1; instr = mk(6'h07, '0); fetch_src = 1'b0; ecc_ue = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset", {ill_o, bus_o}, 2'b00);
    fetch_valid = 1'b0; ecc_ue = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ill_o, bus_o}, 2'b00);
  endtask

  task automatic t_opcode;
    beat("R2 op 0x01 valid", 0, mk(6'h01, 26'h123_4567), 0, 0, 2'b00, 0, 0);
    beat("R2 op 0x07 invalid", 0, mk(6'h07, 26'h000_0001), 0, 0, 2'b00, 1, 0);
    beat("R2 op 0x0F invalid", 0, mk(6'h0F, 26'h155_5555), 0, 0, 2'b00, 1, 0);
    beat("R2 op 0x3F invalid", 0, mk(6'h3F, 26'h3FF_FFFF), 0, 0, 2'b00, 1, 0);
    beat("R2 op 0x20 valid", 0, mk(6'h20, 26'h0AA_AAAA), 0, 0, 2'b00, 0, 0);
  endtask

  task automatic t_low_bits;
    beat("R3 0x07 low zero", 0, mk(6'h07, 26'h000_0000), 0, 0, 2'b00, 1, 0);
    beat("R3 0x07 low ones", 0, mk(6'h07, 26'h3FF_FFFF), 0, 0, 2'b00, 1, 0);
    beat("R3 0x20 low ones", 0, mk(6'h20, 26'h3FF_FFFF), 0, 0, 2'b00, 0, 0);
    beat("R3 0x20 low zero", 0, mk(6'h20, 26'h000_0000), 0, 0, 2'b00, 0, 0);
  endtask

  task automatic t_optional;
    opt_en = 2'b11;
    beat("R4 0x10 enabled", 0, mk(6'h10, 26'h1), 0, 0, 2'b00, 0, 0);
    beat("R4 0x12 enabled", 0, mk(6'h12, 26'h1), 0, 0, 2'b00, 0, 0);
    opt_en = 2'b01;
    beat("R4 0x12 grp1 off", 0, mk(6'h12, 26'h1), 0, 0, 2'b00, 1, 0);
    beat("R4 0x16 grp1 off", 0, mk(6'h16, 26'h1), 0, 0, 2'b00, 1, 0);
    beat("R4 0x10 grp0 on", 0, mk(6'h10, 26'h1), 0, 0, 2'b00, 0, 0);
    opt_en = 2'b10;
    beat("R4 0x10 grp0 off", 0, mk(6'h10, 26'h1), 0, 0, 2'b00, 1, 0);
    beat("R4 0x16 grp1 on", 0, mk(6'h16, 26'h1), 0, 0, 2'b00, 0, 0);
    opt_en = 2'b11;
  endtask

  task automatic t_zero;
    zero_en = 1'b1;
    beat("R5 zero word on", 0, 32'h0000_0000, 0, 0, 2'b00, 1, 0);
    beat("R5 op0 nonzero", 0, 32'h0000_0001, 0, 0, 2'b00, 0, 0);
    zero_en = 1'b0;
    beat("R5 zero word off", 0, 32'h0000_0000, 0, 0, 2'b00, 0, 0);
    zero_en = 1'b1;
  endtask

  task automatic t_local_ecc;
    ce_rep = 1'b0;
    beat("R6 ue", 0, mk(6'h01, 26'h5), 1, 0, 2'b00, 0, 1);
    beat("R7 ce unreported", 0, mk(6'h01, 26'h5), 0, 1, 2'b00, 0, 0);
    ce_rep = 1'b1;
    beat("R7 ce reported", 0, mk(6'h01, 26'h5), 0, 1, 2'b00, 0, 1);
    beat("R8 lmem ignores resp", 0, mk(6'h01, 26'h5), 0, 0, 2'b10, 0, 0);
  endtask

  task automatic t_cached;
    cache_en = 1'b1; inhibit = 1'b0;
    beat("R8 cached err ignored", 1, mk(6'h01, 26'h9), 0, 0, 2'b10, 0, 0);
    beat("R8 cached ecc ignored", 1, mk(6'h01, 26'h9), 1, 1, 2'b00, 0, 0);
    inhibit = 1'b1;
    beat("R8 inhibit err", 1, mk(6'h01, 26'h9), 0, 0, 2'b11, 0, 1);
    cache_en = 1'b0; inhibit = 1'b0;
    beat("R8 cache off err", 1, mk(6'h01, 26'h9), 0, 0, 2'b01, 0, 1);
    beat("R8 cache off okay", 1, mk(6'h01, 26'h9), 0, 0, 2'b00, 0, 0);
    cache_en = 1'b1;
  endtask

  task automatic t_priority;
    beat("R10 illegal over ue", 0, mk(6'h3F, 26'h0), 1, 0, 2'b00, 1, 0);
    cache_en = 1'b0;
    beat("R10 illegal over cbus", 1, mk(6'h07, 26'h0), 0, 0, 2'b10, 1, 0);
    cache_en = 1'b1;
  endtask

  task automatic t_idle_and_b2b;
    // idle: faulty status present but no valid beat
    fetch_valid = 1'b0; instr = mk(6'h07, '0); fetch_src = 1'b0; ecc_ue = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle no pulse", {ill_o, bus_o}, 2'b00);
    // back-to-back beats: illegal then bus
    fetch_valid = 1'b1; instr = mk(6'h0F, '0); ecc_ue = 1'b0;
    @(negedge clk);
    chk("R9 b2b first", {ill_o, bus_o}, 2'b10);
    instr = mk(6'h01, '0); ecc_ue = 1'b1;
    @(negedge clk);
    chk("R9 b2b second", {ill_o, bus_o}, 2'b01);
    fetch_valid = 1'b0; ecc_ue = 1'b0;
    @(negedge clk);
    chk("R9 b2b end", {ill_o, bus_o}, 2'b00);
  endtask

  initial begin
    t_reset();
    t_opcode();
    t_low_bits();
    t_optional();
    t_zero();
    t_local_ecc();
    t_cached();
    t_priority();
    t_idle_and_b2b();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule